// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Fetch Redirect

This block holds the control-hazard logic for a five-stage in-order integer pipeline that fetches under a predict-not-taken policy. It owns the fetch PC register and the IF/ID pipeline register. Each cycle it advances the PC by four and latches the fetched word with its address. It decodes the instruction held in IF/ID and gives the register file the two source indices. The register file returns the two operand values, which the block compares in the decode stage to decide whether a conditional branch is taken.

A dedicated adder forms the taken target from the IF/ID address and the branch offset. When a branch resolves taken, the block steers the PC to that target. On the same edge it clears the wrong-path word that has just been fetched, so a taken branch costs a single bubble and a not-taken branch costs nothing. A stall input from the hazard-detection logic freezes the PC and IF/ID, and no redirect or squash happens while it is high.

Top module: `branch_resolve_id`

## Requirements
- R1: While `rst_n` is low at a clock edge, the PC loads `RESET_PC` (default 0), and the IF/ID word and IF/ID address both clear to 0.
- R2: With `stall` low and no taken branch, each edge adds 4 to the PC, and IF/ID captures `fetch_instr` together with the PC it was fetched from. `pc_sel` then reads 0.
- R3: The opcode is bits [31:26] of the IF/ID word. Opcode 6'h04 (branch-if-equal) is taken when the two operands are equal. Opcode 6'h05 (branch-if-not-equal) is taken when they differ. Every other opcode is never taken, whatever the operands.
- R4: The taken target is IF/ID address + 4 + (sign-extended bits [15:0] shifted left by 2). It appears on `next_pc` in the same cycle the branch sits in IF/ID, for both forward and backward offsets.
- R5: On a taken branch, `flush` and `pc_sel`=1 are raised. At the next edge the PC loads the target and the IF/ID word is cleared to 0, both on that one edge.
- R6: A taken branch costs exactly one bubble. In the cycle after the redirect, `flush` is low and fetch continues sequentially from the target. A not-taken branch causes no flush and no change to sequential fetch.
- R7: While `stall` is high, `flush` is low, `pc_sel` is 2, `next_pc` equals the current PC, and the PC, IF/ID word and IF/ID address keep their values at the edge. A taken branch held under stall redirects once `stall` drops.
- R8: `rs_idx` presents IF/ID bits [25:21] and `rt_idx` presents bits [20:16], combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freeze request from hazard detection |
| fetch_instr | input | 32 | Word read from instruction memory at `fetch_pc` |
| rs_val | input | XLEN | Operand read for `rs_idx` |
| rt_val | input | XLEN | Operand read for `rt_idx` |
| fetch_pc | output | PC_W | Current fetch address (PC register) |
| next_pc | output | PC_W | Value the PC loads at the next edge |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch target, 2 hold |
| flush | output | 1 | Squash of the word being fetched into IF/ID |
| ifid_instr | output | 32 | IF/ID instruction word (0 after a squash) |
| ifid_pc | output | PC_W | IF/ID instruction address |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source register index |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before the first check, and that `stall` and the operand values are stable across each rising edge. They also take it that the operand values belong to the instruction now in IF/ID. The bench drives every input only just after a rising edge and holds it until the next edge. It presents operand values only while the intended branch sits in IF/ID and sets them to differing values otherwise, so the condition checks see the same assumed relationship.

// File: rtl/brres_pkg.sv
// Package: shared encodings for the decode-stage branch resolver.
// Assumes 32-bit instruction words with a fixed field layout.
package brres_pkg;
    localparam int ILEN = 32;

    localparam logic [5:0] OP_BEQ = 6'h04;
    localparam logic [5:0] OP_BNE = 6'h05;

    // Source of the next fetch address
    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_TARGET = 2'd1,
        SEL_HOLD   = 2'd2
    } pc_sel_e;

    // Instruction field layout
    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [15:0] imm;
    } ifield_t;
endpackage

// File: rtl/br_cond.sv
// Module: br_cond
// Decodes the IF/ID word and evaluates the branch condition in decode.
// Assumes the operand values match the rs/rt indices it presents.
module br_cond
    import brres_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic [4:0]      rs,
    output logic [4:0]      rt,
    output logic [15:0]     imm,
    output logic            taken
);
    ifield_t f;
    logic    same;

    assign f = ifield_t'(instr);

    // Field extraction and equality/inequality decision
    always_comb begin
        rs    = f.rs;
        rt    = f.rt;
        imm   = f.imm;
        same  = (op_a == op_b);
        unique case (f.op)
            OP_BEQ:  taken = same;
            OP_BNE:  taken = !same;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
// Module: br_target
// Dedicated decode-stage adder: branch address + 4 + (sext(imm) << 2).
// Assumes PC_W >= 18 so the shifted offset fits.
module br_target #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] base_pc,
    input  logic [15:0]     imm,
    output logic [PC_W-1:0] target
);
    localparam int EXT_W = PC_W - 18;

    logic [PC_W-1:0] offset;

    // Sign-extend, scale to words, and add to the link address
    always_comb begin
        offset = {{EXT_W{imm[15]}}, imm, 2'b00};
        target = base_pc + PC_W'(4) + offset;
    end
endmodule

// File: rtl/fetch_state.sv
// Module: fetch_state
// Holds the PC and IF/ID registers and chooses the next PC.
// Assumes redirect never arrives while stall is high (the top gates it).
module fetch_state
    import brres_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            redirect,
    input  logic [PC_W-1:0] target,
    input  logic [ILEN-1:0] fetch_instr,
    output logic [PC_W-1:0] pc_q,
    output logic [PC_W-1:0] pc_nxt,
    output pc_sel_e         sel,
    output logic [ILEN-1:0] ifid_instr_q,
    output logic [PC_W-1:0] ifid_pc_q
);
    // Select the next-PC source with stall taking priority
    always_comb begin
        if (stall) begin
            sel    = SEL_HOLD;
            pc_nxt = pc_q;
        end else if (redirect) begin
            sel    = SEL_TARGET;
            pc_nxt = target;
        end else begin
            sel    = SEL_SEQ;
            pc_nxt = pc_q + PC_W'(4);
        end
    end

    // PC register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_nxt;
    end

    // IF/ID register: hold on stall, squash on redirect, else capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifid_instr_q <= '0;
            ifid_pc_q    <= '0;
        end else if (stall) begin
            ifid_instr_q <= ifid_instr_q;
            ifid_pc_q    <= ifid_pc_q;
        end else if (redirect) begin
            ifid_instr_q <= '0;
            ifid_pc_q    <= pc_q;
        end else begin
            ifid_instr_q <= fetch_instr;
            ifid_pc_q    <= pc_q;
        end
    end

    assert_squash_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (ifid_instr_q == '0));

    assert_target_loaded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (pc_q == $past(target)));

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(pc_q) && $stable(ifid_instr_q) && $stable(ifid_pc_q)));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !redirect) |=> (pc_q == $past(pc_q) + PC_W'(4)));
endmodule

// File: rtl/branch_resolve_id.sv
// Module: branch_resolve_id (top)
// Resolves conditional branches in decode, redirects fetch and squashes
// the wrong-path word. Assumes operands arrive from the register file
// for the rs_idx/rt_idx it drives, and that stall comes from hazard logic.
module branch_resolve_id
    import brres_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic [31:0]     fetch_instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] next_pc,
    output logic [1:0]      pc_sel,
    output logic            flush,
    output logic [31:0]     ifid_instr,
    output logic [PC_W-1:0] ifid_pc,
    output logic [4:0]      rs_idx,
    output logic [4:0]      rt_idx
);
    logic            taken;
    logic            redirect;
    logic [15:0]     imm;
    logic [PC_W-1:0] target;
    pc_sel_e         sel;

    br_cond #(.XLEN(XLEN)) u_cond (
        .instr (ifid_instr),
        .op_a  (rs_val),
        .op_b  (rt_val),
        .rs    (rs_idx),
        .rt    (rt_idx),
        .imm   (imm),
        .taken (taken)
    );

    br_target #(.PC_W(PC_W)) u_target (
        .base_pc (ifid_pc),
        .imm     (imm),
        .target  (target)
    );

    // A taken branch redirects only when the pipeline is not frozen
    always_comb begin
        redirect = taken && !stall;
        flush    = redirect;
        pc_sel   = sel;
    end

    fetch_state #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall        (stall),
        .redirect     (redirect),
        .target       (target),
        .fetch_instr  (fetch_instr),
        .pc_q         (fetch_pc),
        .pc_nxt       (next_pc),
        .sel          (sel),
        .ifid_instr_q (ifid_instr),
        .ifid_pc_q    (ifid_pc)
    );

    assert_one_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    assert_no_flush_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !flush);

    assert_nonbranch_never_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_instr[31:26] != OP_BEQ && ifid_instr[31:26] != OP_BNE) |-> !flush);
endmodule

// File: tb/test_branch_resolve_id.sv
// Directed bench for branch_resolve_id: one task per scenario.
module test_branch_resolve_id;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            stall;
    logic [31:0]     fetch_instr;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [PC_W-1:0] fetch_pc;
    logic [PC_W-1:0] next_pc;
    logic [1:0]      pc_sel;
    logic            flush;
    logic [31:0]     ifid_instr;
    logic [PC_W-1:0] ifid_pc;
    logic [4:0]      rs_idx;
    logic [4:0]      rt_idx;

    int checks = 0;
    int errors = 0;
    logic [PC_W-1:0] pc_m;  // bench model of the PC

    branch_resolve_id #(.XLEN(XLEN), .PC_W(PC_W)) i_branch_resolve_id (
        .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_instr(fetch_instr),
        .rs_val(rs_val), .rt_val(rt_val), .fetch_pc(fetch_pc), .next_pc(next_pc),
        .pc_sel(pc_sel), .flush(flush), .ifid_instr(ifid_instr), .ifid_pc(ifid_pc),
        .rs_idx(rs_idx), .rt_idx(rt_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [PC_W-1:0] tgt(input logic [PC_W-1:0] bpc, input logic [15:0] imm);
        return bpc + 4 + {{(PC_W-18){imm[15]}}, imm, 2'b00};
    endfunction

    // Place a word into IF/ID through normal fetch; returns its address
    task automatic load(input logic [31:0] w, output logic [PC_W-1:0] at);
        stall = 1'b0;
        fetch_instr = w;
        rs_val = 32'd1;
        rt_val = 32'd2;
        at = pc_m;
        tick();
        pc_m = pc_m + 4;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; stall = 1'b0; fetch_instr = 32'hDEAD_BEEF;
        rs_val = 32'd1; rt_val = 32'd2;
        tick(); tick();
        check(fetch_pc == 0, "R1 pc", fetch_pc, 0);
        check(ifid_instr == 0, "R1 ifid_instr", ifid_instr, 0);
        check(ifid_pc == 0, "R1 ifid_pc", ifid_pc, 0);
        rst_n = 1'b1;
        pc_m = 0;
    endtask

    task automatic t_sequential();
        logic [PC_W-1:0] a;
        for (int i = 0; i < 3; i++) begin
            load(32'h2000_0000 + i, a);
            check(fetch_pc == pc_m, "R2 pc step", fetch_pc, pc_m);
            check(ifid_instr == 32'h2000_0000 + i, "R2 ifid word", ifid_instr, 32'h2000_0000 + i);
            check(ifid_pc == a, "R2 ifid pc", ifid_pc, a);
            check(pc_sel == 2'd0, "R2 pc_sel", {30'd0, pc_sel}, 0);
        end
    endtask

    // Taken branch: same-cycle target, squash, then one bubble only
    task automatic t_taken(input logic [5:0] op, input logic [15:0] imm,
                           input logic [31:0] a_v, input logic [31:0] b_v, input string tag);
        logic [PC_W-1:0] bpc, t, a;
        load(mk(op, 5'd3, 5'd4, imm), bpc);
        rs_val = a_v; rt_val = b_v;
        fetch_instr = 32'h1111_1111;
        #1;
        t = tgt(bpc, imm);
        check(flush == 1'b1, {tag, " R3 taken flush"}, {31'd0, flush}, 1);
        check(next_pc == t, {tag, " R4 target"}, next_pc, t);
        check(pc_sel == 2'd1, {tag, " R5 pc_sel"}, {30'd0, pc_sel}, 1);
        tick();
        pc_m = t;
        check(fetch_pc == t, {tag, " R5 pc loaded"}, fetch_pc, t);
        check(ifid_instr == 0, {tag, " R5 ifid cleared"}, ifid_instr, 0);
        rs_val = 32'd5; rt_val = 32'd5;
        #1;
        check(flush == 1'b0, {tag, " R6 single bubble"}, {31'd0, flush}, 0);
        load(32'h2222_2222, a);
        check(fetch_pc == t + 4, {tag, " R6 resume"}, fetch_pc, t + 4);
        check(ifid_pc == t && ifid_instr == 32'h2222_2222, {tag, " R6 target word"}, ifid_pc, t);
    endtask

    task automatic t_not_taken(input logic [5:0] op, input logic [31:0] a_v,
                               input logic [31:0] b_v, input string tag);
        logic [PC_W-1:0] bpc;
        load(mk(op, 5'd7, 5'd8, 16'h0040), bpc);
        check(rs_idx == 5'd7 && rt_idx == 5'd8, {tag, " R8 indices"}, {27'd0, rs_idx}, 7);
        rs_val = a_v; rt_val = b_v;
        fetch_instr = 32'h3333_3333;
        #1;
        check(flush == 1'b0, {tag, " R3 not taken"}, {31'd0, flush}, 0);
        tick();
        pc_m = pc_m + 4;
        check(fetch_pc == pc_m, {tag, " R6 no bubble pc"}, fetch_pc, pc_m);
        check(ifid_instr == 32'h3333_3333, {tag, " R6 no squash"}, ifid_instr, 32'h3333_3333);
    endtask

    task automatic t_stall();
        logic [PC_W-1:0] bpc, hold_pc, t;
        load(mk(brres_pkg::OP_BNE, 5'd1, 5'd2, 16'h0010), bpc);
        rs_val = 32'd9; rt_val = 32'd10;
        stall = 1'b1;
        fetch_instr = 32'h4444_4444;
        hold_pc = pc_m;
        #1;
        check(flush == 1'b0, "R7 no flush on stall", {31'd0, flush}, 0);
        check(pc_sel == 2'd2 && next_pc == hold_pc, "R7 hold sel", next_pc, hold_pc);
        tick(); tick();
        check(fetch_pc == hold_pc, "R7 pc held", fetch_pc, hold_pc);
        check(ifid_instr == mk(brres_pkg::OP_BNE, 5'd1, 5'd2, 16'h0010), "R7 ifid held",
              ifid_instr, mk(brres_pkg::OP_BNE, 5'd1, 5'd2, 16'h0010));
        check(ifid_pc == bpc, "R7 ifid pc held", ifid_pc, bpc);
        stall = 1'b0;
        #1;
        t = tgt(bpc, 16'h0010);
        check(flush == 1'b1 && next_pc == t, "R7 redirect after stall", next_pc, t);
        tick();
        pc_m = t;
        check(fetch_pc == t && ifid_instr == 0, "R7 late redirect", fetch_pc, t);
    endtask

    task automatic t_other_op();
        logic [PC_W-1:0] bpc;
        load(mk(6'h06, 5'd1, 5'd2, 16'h0100), bpc);
        rs_val = 32'd3; rt_val = 32'd3;
        fetch_instr = 32'h5555_5555;
        #1;
        check(flush == 1'b0 && pc_sel == 2'd0, "R3 other opcode equal", {31'd0, flush}, 0);
        rt_val = 32'd4;
        #1;
        check(flush == 1'b0, "R3 other opcode differ", {31'd0, flush}, 0);
        tick();
        pc_m = pc_m + 4;
        check(fetch_pc == pc_m, "R3 other opcode pc", fetch_pc, pc_m);
    endtask

    initial begin
        t_reset();
        t_sequential();
        t_taken(brres_pkg::OP_BEQ, 16'h0008, 32'd7, 32'd7, "beq fwd");
        t_not_taken(brres_pkg::OP_BEQ, 32'd7, 32'd8, "beq");
        t_taken(brres_pkg::OP_BNE, 16'h0020, 32'd1, 32'd9, "bne fwd");
        t_not_taken(brres_pkg::OP_BNE, 32'hFFFF_0000, 32'hFFFF_0000, "bne");
        t_taken(brres_pkg::OP_BEQ, 16'hFFF0, 32'hABCD, 32'hABCD, "beq back");
        t_stall();
        t_other_op();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule